// File: doc/BRIEF.md
# I2C Indexed Block Register Target

This block is an I2C target that holds a small bank of byte-wide configuration registers and makes every register available in parallel to the rest of the chip. A host programs the bank with an indexed block write: it sends the target address, a starting index, a byte count, and then the data bytes. To read, the host sets the index with a write header, issues a repeated start, and switches to the read address. The target then returns a byte count taken from a dedicated register, followed by data bytes beginning at the chosen index.

The bus pins are handled as sampled inputs plus one open-drain pull-low enable for SDA. Both lines are synchronised and glitch-filtered on a system clock that runs much faster than SCL. Start and stop conditions are detected from SDA edges while SCL is high. The index advances after every data byte. The target never stretches the clock.

Top module: `i2c_idx_target`

## Requirements
- R1: After reset, SDA is released (`sda_oe_o` = 0) and every register in `regs_o` reads 00h.
- R2: The target answers only the 7-bit address 69h, which is D2h for write and D3h for read. Any other address byte gets no ACK. All later bytes of that transfer get no ACK and change no register.
- R3: A write transfer consists of address, index N, count X, and then data bytes. The target ACKs each of these. Data byte k is stored in register N+k, and it appears at `regs_o[8*(N+k) +: 8]`.
- R4: During a write, data bytes after the first X are not acknowledged and are not stored. With X = 0, the first data byte already gets a NACK.
- R5: A data byte whose index is at or beyond `NUM_REGS` (16 by default) is acknowledged and discarded. It never aliases onto a lower register.
- R6: On a read, the target first sends the content of register 8 (`COUNT_IDX`). It then sends registers N, N+1, and so on, MSB first.
- R7: A read at an index at or beyond `NUM_REGS` returns 00h.
- R8: A NACK from the host ends the transmission. SDA stays released, so any further clocked byte reads FFh, until the next start or stop.
- R9: A stop or start seen in the middle of a byte aborts the transfer. A partly received byte is not stored, and the next transfer works normally.
- R10: The target changes SDA only while SCL is low, so SDA is stable during every SCL high phase of a byte it sends.
- R11: A pulse on SCL or SDA that lasts fewer than `FILT_LEN` system clocks has no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| regs_o | output | NUM_REGS*8 | All registers, register i at bits 8*i+7 down to 8*i |

## Verification
Most internal faults in this block show up at the pins within one byte time. A wrong bit counter, a wrong state, or a wrong acknowledge decision moves or drops an ACK bit, and it shifts the bits of a returned byte. A fault in the index or count tracking appears later: either on `regs_o` after the write ends, or as a wrong byte in a read-back. For this reason every write in the bench is followed by a full register comparison, and every read is compared byte by byte. Faults in the abort and filter paths only show up after a later, clean transfer, so each of those tests ends with a normal write and a read.

// File: rtl/i2c_idx_pkg.sv
package i2c_idx_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_INDEX,
    ST_INDEX_ACK,
    ST_COUNT,
    ST_COUNT_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_WAIT
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_filt.sv
module i2c_line_filt #(
  parameter int FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  logic [1:0]          sync_q;
  logic [FILT_LEN-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b11;
      hist_q <= '1;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
      if (&hist_q)       line_o <= 1'b1;
      else if (~|hist_q) line_o <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_idx_regs.sv
module i2c_idx_regs #(
  parameter int NUM_REGS  = 16,
  parameter int COUNT_IDX = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [7:0]            wr_addr_i,
  input  logic [7:0]            wr_data_i,
  input  logic [7:0]            rd_addr_i,
  output logic [7:0]            rd_data_o,
  output logic [7:0]            cnt_data_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam int AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [8:0] NREG9 = 9'(NUM_REGS);

  logic [7:0] regs_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              regs_q[g] <= 8'h00;
      else if (wr_en_i && wr_addr_i == 8'(g))   regs_q[g] <= wr_data_i;
    end
    assign regs_o[g*8 +: 8] = regs_q[g];
  end

  assign rd_data_o  = ({1'b0, rd_addr_i} < NREG9) ? regs_q[rd_addr_i[AW-1:0]] : 8'h00;
  assign cnt_data_o = regs_q[COUNT_IDX];
endmodule

// File: rtl/i2c_idx_fsm.sv
module i2c_idx_fsm
  import i2c_idx_pkg::*;
#(
  parameter logic [6:0] TGT_ADDR = 7'h69,
  parameter int         NUM_REGS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_f_i,
  input  logic       sda_f_i,
  input  logic [7:0] rd_data_i,
  input  logic [7:0] cnt_data_i,
  output logic       sda_oe_o,
  output logic       wr_en_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o,
  output logic [7:0] rd_addr_o,
  output tgt_state_e state_o,
  output logic       start_o,
  output logic       stop_o
);
  localparam logic [8:0] NREG9 = 9'(NUM_REGS);

  tgt_state_e state_q;
  logic       scl_q, sda_q;
  logic [3:0] bit_q;
  logic [7:0] sh_q, idx_q, rem_q;
  logic       rw_q, hack_q, oe_q;
  logic       scl_rise, scl_fall, byte_end;

  assign scl_rise = scl_f_i & ~scl_q;
  assign scl_fall = ~scl_f_i & scl_q;
  assign start_o  = scl_f_i & scl_q & sda_q & ~sda_f_i;
  assign stop_o   = scl_f_i & scl_q & ~sda_q & sda_f_i;
  assign byte_end = scl_fall && bit_q == 4'd8;

  assign wr_en_o   = (state_q == ST_WDATA) && byte_end && rem_q != 8'd0 &&
                     ({1'b0, idx_q} < NREG9);
  assign wr_addr_o = idx_q;
  assign wr_data_o = sh_q;
  assign rd_addr_o = idx_q;
  assign sda_oe_o  = oe_q;
  assign state_o   = state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      scl_q   <= 1'b1;
      sda_q   <= 1'b1;
      bit_q   <= '0;
      sh_q    <= '0;
      idx_q   <= '0;
      rem_q   <= '0;
      rw_q    <= 1'b0;
      hack_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      scl_q <= scl_f_i;
      sda_q <= sda_f_i;
      if (stop_o) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else if (start_o) begin
        state_q <= ST_ADDR;
        bit_q   <= '0;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_INDEX, ST_COUNT, ST_WDATA: begin
            if (scl_rise && bit_q < 4'd8) begin
              sh_q  <= {sh_q[6:0], sda_f_i};
              bit_q <= bit_q + 4'd1;
            end else if (byte_end) begin
              bit_q <= '0;
              if (state_q == ST_ADDR) begin
                if (sh_q[7:1] == TGT_ADDR) begin
                  rw_q    <= sh_q[0];
                  oe_q    <= 1'b1;
                  state_q <= ST_ADDR_ACK;
                end else begin
                  state_q <= ST_WAIT;
                end
              end else if (state_q == ST_INDEX) begin
                idx_q   <= sh_q;
                oe_q    <= 1'b1;
                state_q <= ST_INDEX_ACK;
              end else if (state_q == ST_COUNT) begin
                rem_q   <= sh_q;
                oe_q    <= 1'b1;
                state_q <= ST_COUNT_ACK;
              end else if (rem_q != 8'd0) begin
                rem_q   <= rem_q - 8'd1;
                idx_q   <= idx_q + 8'd1;
                oe_q    <= 1'b1;
                state_q <= ST_WDATA_ACK;
              end else begin
                state_q <= ST_WAIT;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bit_q <= '0;
              if (rw_q) begin
                sh_q    <= cnt_data_i;
                oe_q    <= ~cnt_data_i[7];
                state_q <= ST_TX;
              end else begin
                oe_q    <= 1'b0;
                state_q <= ST_INDEX;
              end
            end
          end
          ST_INDEX_ACK, ST_COUNT_ACK, ST_WDATA_ACK: begin
            if (scl_fall) begin
              oe_q    <= 1'b0;
              state_q <= (state_q == ST_INDEX_ACK) ? ST_COUNT : ST_WDATA;
            end
          end
          ST_TX: begin
            if (scl_rise && bit_q < 4'd8) begin
              bit_q <= bit_q + 4'd1;
            end else if (scl_fall) begin
              if (bit_q == 4'd8) begin
                oe_q    <= 1'b0;
                bit_q   <= '0;
                state_q <= ST_TX_ACK;
              end else begin
                sh_q <= {sh_q[6:0], 1'b0};
                oe_q <= ~sh_q[6];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              hack_q <= ~sda_f_i;
              bit_q  <= 4'd1;
            end else if (scl_fall && bit_q == 4'd1) begin
              bit_q <= '0;
              if (hack_q) begin
                sh_q    <= rd_data_i;
                oe_q    <= ~rd_data_i[7];
                idx_q   <= idx_q + 8'd1;
                state_q <= ST_TX;
              end else begin
                state_q <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_idx_target.sv
module i2c_idx_target
  import i2c_idx_pkg::*;
#(
  parameter int         NUM_REGS  = 16,
  parameter logic [6:0] TGT_ADDR  = 7'h69,
  parameter int         COUNT_IDX = 8,
  parameter int         FILT_LEN  = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  logic [1:0] raw, filt;
  logic       scl_f, sda_f;
  logic       wr_en;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data, cnt_data;
  logic       start_det, stop_det;
  tgt_state_e state_q;

  assign raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2c_line_filt #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(raw[g]),
      .line_o(filt[g])
    );
  end

  assign scl_f = filt[0];
  assign sda_f = filt[1];

  i2c_idx_fsm #(.TGT_ADDR(TGT_ADDR), .NUM_REGS(NUM_REGS)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_f_i   (scl_f),
    .sda_f_i   (sda_f),
    .rd_data_i (rd_data),
    .cnt_data_i(cnt_data),
    .sda_oe_o  (sda_oe_o),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data),
    .rd_addr_o (rd_addr),
    .state_o   (state_q),
    .start_o   (start_det),
    .stop_o    (stop_det)
  );

  i2c_idx_regs #(.NUM_REGS(NUM_REGS), .COUNT_IDX(COUNT_IDX)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data),
    .cnt_data_o(cnt_data),
    .regs_o    (regs_o)
  );
endmodule

// File: rtl/i2c_idx_target_chk.sv
module i2c_idx_target_chk
  import i2c_idx_pkg::*;
#(
  parameter int NUM_REGS = 16
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sda_oe_o,
  input logic       scl_f,
  input tgt_state_e state_q,
  input logic       start_det,
  input logic       stop_det,
  input logic       wr_en,
  input logic [7:0] wr_addr
);
  // R1 / R8: released whenever not in a phase that may drive
  a_r1_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !sda_oe_o);
  a_r8_wait_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |-> !sda_oe_o);
  // R3: never drive while the host is sending a byte
  a_r3_rx_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q inside {ST_ADDR, ST_INDEX, ST_COUNT, ST_WDATA}) |-> !sda_oe_o);
  // R10: pull-down only starts while SCL is low
  a_r10_drive_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_f);
  // R9: bus conditions abort
  a_r9_start_to_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> (state_q == ST_ADDR));
  a_r9_stop_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (state_q == ST_IDLE));
  // R5: writes stay inside the bank
  a_r5_write_in_bank: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en |-> ({1'b0, wr_addr} < 9'(NUM_REGS)));
endmodule

bind i2c_idx_target i2c_idx_target_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sda_oe_o (sda_oe_o),
  .scl_f    (scl_f),
  .state_q  (state_q),
  .start_det(start_det),
  .stop_det (stop_det),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr)
);

// File: tb/i2c_idx_target_tb.sv
module i2c_idx_target_tb;
  localparam int NR = 16;
  localparam int Q  = 10;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          scl = 1'b1;
  logic          host_low = 1'b0;
  logic          sda_oe;
  logic          sda_bus;
  logic [NR*8-1:0] regs;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [7:0] exp_r [NR];
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [32];

  always #4 clk = ~clk;

  assign sda_bus = ~(host_low | sda_oe);

  i2c_idx_target u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .scl_i   (scl),
    .sda_i   (sda_bus),
    .sda_oe_o(sda_oe),
    .regs_o  (regs)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    host_low = 1'b0; wq(Q);
    scl = 1'b1; wq(Q);
    host_low = 1'b1; wq(Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic i2c_stop();
    host_low = 1'b1; wq(Q);
    scl = 1'b1; wq(Q);
    host_low = 1'b0; wq(2*Q);
  endtask

  // gm: 1 = SCL glitch in low phase of bit 4, 2 = SDA glitch in high phase of bit 4
  task automatic send_bits(input logic [7:0] b, input int nb, input int gm);
    for (int i = 7; i > 7 - nb; i--) begin
      host_low = ~b[i];
      if (gm == 1 && i == 4) begin
        wq(Q/2); scl = 1'b1; wq(1); scl = 1'b0; wq(Q - Q/2 - 1);
      end else begin
        wq(Q);
      end
      scl = 1'b1;
      if (gm == 2 && i == 4 && b[i]) begin
        wq(Q); host_low = 1'b1; wq(1); host_low = 1'b0; wq(Q - 1);
      end else begin
        wq(2*Q);
      end
      scl = 1'b0; wq(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input int gm, output bit acked);
    send_bits(b, 8, gm);
    host_low = 1'b0; wq(Q);
    scl = 1'b1; wq(Q);
    acked = ~sda_bus;
    wq(Q);
    scl = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input bit ack, output logic [7:0] b, output bit stable);
    logic s0, s1;
    host_low = 1'b0;
    stable = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q);
      scl = 1'b1; wq(1);
      s0 = sda_bus; wq(Q - 1);
      b[i] = sda_bus; wq(Q - 1);
      s1 = sda_bus; wq(1);
      if (s0 != b[i] || s1 != b[i]) stable = 1'b0;
      scl = 1'b0;
    end
    wq(Q);
    host_low = ack; wq(Q);
    scl = 1'b1; wq(2*Q);
    scl = 1'b0; wq(Q);
    host_low = 1'b0;
  endtask

  task automatic check_regs(input string tag);
    for (int i = 0; i < NR; i++)
      chk(regs[i*8 +: 8] == exp_r[i], tag, int'(regs[i*8 +: 8]), int'(exp_r[i]));
  endtask

  // indexed block write; gm applied to data byte gk
  task automatic wr_xfer(input logic [7:0] n, input logic [7:0] x, input int nd,
                         input int gm, input int gk, input string tag);
    bit a;
    i2c_start();
    send_byte(8'hD2, 0, a); chk(a, {tag, " addr ack"}, a, 1);
    send_byte(n, 0, a);     chk(a, {tag, " index ack"}, a, 1);
    send_byte(x, 0, a);     chk(a, {tag, " count ack"}, a, 1);
    for (int k = 0; k < nd; k++) begin
      send_byte(wbuf[k], (k == gk) ? gm : 0, a);
      chk(a == (k < int'(x)), {tag, " data ack"}, a, int'(k < int'(x)));
      if (k < int'(x) && int'(n) + k < NR) exp_r[int'(n) + k] = wbuf[k];
    end
    i2c_stop();
    check_regs(tag);
  endtask

  task automatic rd_xfer(input logic [7:0] n, input int nd, input bit extra, input string tag);
    bit a, st;
    logic [7:0] v;
    i2c_start();
    send_byte(8'hD2, 0, a); chk(a, {tag, " waddr ack"}, a, 1);
    send_byte(n, 0, a);     chk(a, {tag, " index ack"}, a, 1);
    i2c_start();
    send_byte(8'hD3, 0, a); chk(a, {tag, " raddr ack"}, a, 1);
    recv_byte(1'b1, v, st);
    chk(v == exp_r[8], {tag, " R6 count byte"}, v, exp_r[8]);
    chk(st, {tag, " R10 sda stable"}, st, 1);
    for (int k = 0; k < nd; k++) begin
      logic [7:0] e;
      e = (int'(n) + k < NR) ? exp_r[int'(n) + k] : 8'h00;
      recv_byte(k != nd - 1, v, st);
      chk(v == e, {tag, " data"}, v, e);
      chk(st, {tag, " R10 sda stable"}, st, 1);
    end
    if (extra) begin
      recv_byte(1'b0, v, st);
      chk(v == 8'hFF, {tag, " R8 released after nack"}, v, 8'hFF);
    end
    i2c_stop();
  endtask

  initial begin
    for (int i = 0; i < NR; i++) exp_r[i] = 8'h00;
    wq(5);
    rst_ni = 1'b1;
    wq(20);
    // R1
    chk(sda_oe == 1'b0, "R1 sda released", sda_oe, 0);
    check_regs("R1 reset regs");

    // R3 sweep of start index and count
    begin
      int ns [4] = '{0, 3, 12, 7};
      int xs [4] = '{16, 4, 4, 1};
      for (int p = 0; p < 4; p++) begin
        for (int k = 0; k < xs[p]; k++) wbuf[k] = 8'(ns[p]*17 + k*5 + 1 + p*3);
        wr_xfer(8'(ns[p]), 8'(xs[p]), xs[p], 0, -1, "R3 write");
      end
    end

    // R4 surplus data bytes and zero count
    for (int k = 0; k < 4; k++) wbuf[k] = 8'hA0 + 8'(k);
    wr_xfer(8'd2, 8'd2, 4, 0, -1, "R4 over count");
    wbuf[0] = 8'h77;
    wr_xfer(8'd4, 8'd0, 1, 0, -1, "R4 zero count");

    // R5 past the bank end, no aliasing onto 0/1
    for (int k = 0; k < 4; k++) wbuf[k] = 8'hC0 + 8'(k);
    wr_xfer(8'd14, 8'd4, 4, 0, -1, "R5 past end");

    // R2 foreign addresses
    begin
      logic [7:0] bad_addr [3] = '{8'hA4, 8'hD0, 8'h52};
      for (int j = 0; j < 3; j++) begin
        bit a;
        i2c_start();
        send_byte(bad_addr[j], 0, a); chk(!a, "R2 foreign addr nack", a, 0);
        send_byte(8'h00, 0, a);       chk(!a, "R2 following byte nack", a, 0);
        send_byte(8'h55, 0, a);       chk(!a, "R2 following byte nack", a, 0);
        i2c_stop();
        check_regs("R2 regs unchanged");
      end
    end

    // R6 / R7 / R8 reads
    wbuf[0] = 8'h03;
    wr_xfer(8'd8, 8'd1, 1, 0, -1, "R6 set count reg");
    rd_xfer(8'd0, 3, 1'b0, "R6 read idx0");
    rd_xfer(8'd5, 6, 1'b1, "R6 read idx5");
    rd_xfer(8'd14, 4, 1'b1, "R7 read past end");

    // R9 stop in mid byte
    begin
      bit a;
      i2c_start();
      send_byte(8'hD2, 0, a);
      send_byte(8'd9, 0, a);
      send_byte(8'd3, 0, a);
      send_byte(8'h11, 0, a); chk(a, "R9 first data ack", a, 1);
      exp_r[9] = 8'h11;
      send_bits(8'h22, 4, 0);
      i2c_stop();
      check_regs("R9 stop abort");
      // start in mid index byte
      i2c_start();
      send_byte(8'hD2, 0, a);
      send_bits(8'hFF, 3, 0);
      i2c_start();
      send_byte(8'hD2, 0, a); chk(a, "R9 restart addr ack", a, 1);
      send_byte(8'd10, 0, a);
      send_byte(8'd1, 0, a);
      send_byte(8'h33, 0, a); chk(a, "R9 restart data ack", a, 1);
      exp_r[10] = 8'h33;
      i2c_stop();
      check_regs("R9 start abort");
    end

    // R11 glitches on SCL and on SDA
    wbuf[0] = 8'h5A; wbuf[1] = 8'h96;
    wr_xfer(8'd1, 8'd2, 2, 1, 0, "R11 scl glitch");
    wbuf[0] = 8'h5B; wbuf[1] = 8'h3C;
    wr_xfer(8'd6, 8'd2, 2, 2, 0, "R11 sda glitch");
    rd_xfer(8'd0, 16, 1'b0, "R11 readback");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule